// File: doc/BRIEF.md
# Page-Buffer Operation Sequencer

This block carries out one page-level command at a time against a small on-chip main array and two page-sized holding buffers. A command is a single-cycle strobe. It carries an operation code, a buffer choice, a page number and a page-length mode. The block then runs on its own until the operation is finished. Three operations exist. A copy moves the addressed page into the chosen buffer. A check compares the page with the buffer byte by byte. A refresh copies the page into the buffer, erases the page to all-ones, waits out an erase latency, programs the buffer back into the page and waits out a program latency. The erase and program latencies are modelled by parameterised wait counters.

While an operation runs, the block reports busy on its `busy` pin and in bit 7 of its status byte. The result of the most recent check stays in bit 6 of the status byte until the next check finishes. A host byte port loads the array and the buffers while the block is idle. A separate read port lets the host inspect any byte at any time.

Page length is selected per command. Standard mode uses `STD_LEN` bytes (default 17) and binary mode uses `BIN_LEN` bytes (default 16). In binary mode the trailing standard-only byte positions are neither read nor written.

The controller is a state machine with seven states:
- IDLE: waiting for a command.
- FETCH: page to buffer, one byte per cycle.
- CMP: byte comparison, one byte per cycle.
- ERASE: writes FFh, one byte per cycle.
- EWAIT: erase latency.
- PROG: buffer to page, one byte per cycle.
- PWAIT: program latency.

Its transitions are:
- IDLE→FETCH on an accepted copy or refresh strobe.
- IDLE→CMP on an accepted check strobe.
- FETCH→IDLE after the last byte of a copy.
- FETCH→ERASE after the last byte of a refresh.
- CMP→IDLE after the last byte.
- ERASE→EWAIT after the last byte.
- EWAIT→PROG when the erase count expires.
- PROG→PWAIT after the last byte.
- PWAIT→IDLE when the program count expires.

Top module: `page_op_sequencer`

## Requirements
- R1: After reset, `busy` is 0 and `status` reads 8'h80.
- R2: A copy (`cmd_op`=2'b00) writes each byte of the addressed page into the chosen buffer (`cmd_buf`=0 first buffer, 1 second buffer) at the same byte position. The other buffer and the main array are left unchanged.
- R3: With `cmd_bin`=0 an operation covers byte positions 0..STD_LEN-1. With `cmd_bin`=1 it covers 0..BIN_LEN-1, and positions BIN_LEN and above are neither copied nor compared.
- R4: A check (`cmd_op`=2'b01) sets `status[6]` to 0 when every covered byte of the page equals the buffer, and to 1 when any byte differs, the last byte included. The flag changes only when a check finishes. Memory and buffers are left unchanged.
- R5: A refresh (`cmd_op`=2'b10) copies the page into the chosen buffer, then erases the page. Exactly 2·len cycles after acceptance, every covered byte of the page reads FFh. The buffer is then programmed back, so the page ends with its original contents and the buffer holds a copy of it.
- R6: `busy` rises, and `status[7]` falls, in the cycle after a command is accepted. Busy lasts len cycles for a copy or a check, and 3·len + ERASE_CYCLES + PROG_CYCLES cycles for a refresh.
- R7: A strobe while busy has no effect on the running operation. A strobe with `cmd_op`=2'b11 is ignored and does not raise busy.
- R8: Host writes (`host_sel` 0 = first buffer, 1 = second buffer, 2 = main array, 3 = nothing) take effect only while idle. `rd_data` returns the byte chosen by `rd_sel`, `rd_page` and `rd_idx` using the same `host_sel` encoding, and returns 0 for selector 3.
- R9: A copy or a refresh leaves `status[6]` at the value of the last check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 00 copy, 01 check, 10 refresh, 11 none |
| cmd_buf | input | 1 | Buffer choice |
| cmd_page | input | PAGE_W | Page number |
| cmd_bin | input | 1 | 1 = binary page length |
| host_we | input | 1 | Host byte write strobe |
| host_sel | input | 2 | Host write target |
| host_page | input | PAGE_W | Host write page (main array only) |
| host_idx | input | IDX_W | Host write byte position |
| host_wdata | input | 8 | Host write data |
| rd_sel | input | 2 | Read target |
| rd_page | input | PAGE_W | Read page |
| rd_idx | input | IDX_W | Read byte position |
| rd_data | output | 8 | Read data (combinational) |
| busy | output | 1 | Operation in progress |
| status | output | 8 | bit7 ready, bit6 last check mismatch, others 0 |

## Verification
The hardest state to observe is the erased page in the middle of a refresh. It lasts only ERASE_CYCLES cycles and disappears once programming begins. The bench counts cycles from the acceptance edge and queues its reads of the page at exactly 2·len cycles, so the monitor samples them inside the erase wait. Strobes and host writes are also injected partway through a running copy. The bench then proves, through the read port and the busy length, that they changed nothing.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [1:0] {
        OP_COPY  = 2'b00,
        OP_CHECK = 2'b01,
        OP_REFR  = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CMP,
        S_ERASE,
        S_EWAIT,
        S_PROG,
        S_PWAIT
    } seq_state_e;

    localparam logic [1:0] TGT_BUF0 = 2'd0;
    localparam logic [1:0] TGT_BUF1 = 2'd1;
    localparam logic [1:0] TGT_MAIN = 2'd2;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/pbs_store.sv
module pbs_store
    import pbs_pkg::*;
#(
    parameter int PAGES  = 4,
    parameter int LEN    = 17,
    parameter int IDX_W  = 5,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              main_we,
    input  logic [PAGE_W-1:0] main_page,
    input  logic [IDX_W-1:0]  main_idx,
    input  logic [7:0]        main_wd,
    input  logic              buf_we,
    input  logic              buf_sel,
    input  logic [IDX_W-1:0]  buf_idx,
    input  logic [7:0]        buf_wd,
    input  logic [PAGE_W-1:0] seq_page,
    input  logic              seq_sel,
    input  logic [IDX_W-1:0]  seq_idx,
    output logic [7:0]        seq_main_rd,
    output logic [7:0]        seq_buf_rd,
    input  logic [1:0]        h_sel,
    input  logic [PAGE_W-1:0] h_page,
    input  logic [IDX_W-1:0]  h_idx,
    output logic [7:0]        h_rd
);

    localparam int CELLS = PAGES * LEN;
    localparam int AW    = (CELLS > 1) ? $clog2(CELLS) : 1;

    function automatic logic [AW-1:0] lin(input logic [PAGE_W-1:0] p,
                                          input logic [IDX_W-1:0]  i);
        return AW'(int'(p) * LEN + int'(i));
    endfunction

    function automatic logic in_page(input logic [IDX_W-1:0] i);
        return int'(i) < LEN;
    endfunction

    logic [7:0] main_q [CELLS];

    always_ff @(posedge clk) begin
        if (main_we && in_page(main_idx))
            main_q[lin(main_page, main_idx)] <= main_wd;
    end

    assign seq_main_rd = in_page(seq_idx) ? main_q[lin(seq_page, seq_idx)] : 8'h00;

    logic [7:0] seq_b_rd  [2];
    logic [7:0] host_b_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic [7:0] bq [LEN];
        always_ff @(posedge clk) begin
            if (buf_we && (buf_sel == 1'(b)) && in_page(buf_idx))
                bq[buf_idx] <= buf_wd;
        end
        assign seq_b_rd[b]  = in_page(seq_idx) ? bq[seq_idx] : 8'h00;
        assign host_b_rd[b] = in_page(h_idx)   ? bq[h_idx]   : 8'h00;
    end

    assign seq_buf_rd = seq_b_rd[seq_sel];

    always_comb begin
        h_rd = 8'h00;
        if (in_page(h_idx)) begin
            unique case (h_sel)
                TGT_BUF0: h_rd = host_b_rd[0];
                TGT_BUF1: h_rd = host_b_rd[1];
                TGT_MAIN: h_rd = main_q[lin(h_page, h_idx)];
                default:  h_rd = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/pbs_seq.sv
module pbs_seq
    import pbs_pkg::*;
#(
    parameter int STD_LEN      = 17,
    parameter int BIN_LEN      = 16,
    parameter int ERASE_CYCLES = 5,
    parameter int PROG_CYCLES  = 4,
    parameter int IDX_W        = 5,
    parameter int PAGE_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_buf,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              cmd_bin,
    input  logic [7:0]        main_rd,
    input  logic [7:0]        buf_rd,
    output logic              main_we,
    output logic [7:0]        main_wd,
    output logic              buf_we,
    output logic [PAGE_W-1:0] cur_page,
    output logic              cur_sel,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              busy,
    output logic [7:0]        status
);

    localparam int WMAX = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int WW   = $clog2(WMAX) + 1;
    localparam logic [IDX_W-1:0] STD_LAST = IDX_W'(STD_LEN - 1);
    localparam logic [IDX_W-1:0] BIN_LAST = IDX_W'(BIN_LEN - 1);
    localparam logic [WW-1:0]    E_LAST   = WW'(ERASE_CYCLES - 1);
    localparam logic [WW-1:0]    P_LAST   = WW'(PROG_CYCLES - 1);

    seq_state_e        state_q, state_d;
    op_e               op_q;
    logic [PAGE_W-1:0] page_q;
    logic              sel_q;
    logic [IDX_W-1:0]  idx_q, last_q;
    logic [WW-1:0]     wait_q;
    logic              miss_q, flag_q;

    logic accept, at_last, byte_diff;

    assign accept    = (state_q == S_IDLE) && cmd_go && (op_e'(cmd_op) != OP_NONE);
    assign at_last   = (idx_q == last_q);
    assign byte_diff = (main_rd != buf_rd);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept)
                         state_d = (op_e'(cmd_op) == OP_CHECK) ? S_CMP : S_FETCH;
            S_FETCH: if (at_last)
                         state_d = (op_q == OP_REFR) ? S_ERASE : S_IDLE;
            S_CMP:   if (at_last) state_d = S_IDLE;
            S_ERASE: if (at_last) state_d = S_EWAIT;
            S_EWAIT: if (wait_q == E_LAST) state_d = S_PROG;
            S_PROG:  if (at_last) state_d = S_PWAIT;
            S_PWAIT: if (wait_q == P_LAST) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and per-operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_NONE;
            page_q  <= '0;
            sel_q   <= 1'b0;
            idx_q   <= '0;
            last_q  <= STD_LAST;
            wait_q  <= '0;
            miss_q  <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q   <= op_e'(cmd_op);
                page_q <= cmd_page;
                sel_q  <= cmd_buf;
                last_q <= cmd_bin ? BIN_LAST : STD_LAST;
                idx_q  <= '0;
                miss_q <= 1'b0;
            end
            unique case (state_q)
                S_FETCH, S_ERASE, S_PROG: idx_q <= at_last ? '0 : idx_q + 1'b1;
                S_CMP: begin
                    idx_q  <= at_last ? '0 : idx_q + 1'b1;
                    miss_q <= miss_q | byte_diff;
                    if (at_last) flag_q <= miss_q | byte_diff;
                end
                default: ;
            endcase
            if ((state_q == S_EWAIT && wait_q != E_LAST) ||
                (state_q == S_PWAIT && wait_q != P_LAST))
                wait_q <= wait_q + 1'b1;
            else
                wait_q <= '0;
        end
    end

    // outputs
    always_comb begin
        main_we  = (state_q == S_ERASE) || (state_q == S_PROG);
        main_wd  = (state_q == S_ERASE) ? ERASED_BYTE : buf_rd;
        buf_we   = (state_q == S_FETCH);
        cur_page = page_q;
        cur_sel  = sel_q;
        cur_idx  = idx_q;
        busy     = (state_q != S_IDLE);
        status   = {~busy, flag_q, 6'b000000};
    end

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_go) |=> ($stable(page_q) && $stable(op_q) && $stable(sel_q)));

    // R7
    noop_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_go && cmd_op == 2'b11) |=> !busy);

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_go && cmd_op != 2'b11) |=> busy);

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_CMP) |=> $stable(flag_q));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx_q <= last_q));

    // R5
    refresh_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH && op_q == OP_REFR && at_last) |=> (state_q == S_ERASE));

    // R6
    erase_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EWAIT) |-> (wait_q <= E_LAST));

endmodule

// File: rtl/page_op_sequencer.sv
module page_op_sequencer
    import pbs_pkg::*;
#(
    parameter int PAGES        = 4,
    parameter int STD_LEN      = 17,
    parameter int BIN_LEN      = 16,
    parameter int ERASE_CYCLES = 5,
    parameter int PROG_CYCLES  = 4,
    localparam int IDX_W       = $clog2(STD_LEN),
    localparam int PAGE_W      = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_buf,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              cmd_bin,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [PAGE_W-1:0] host_page,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [7:0]        host_wdata,
    input  logic [1:0]        rd_sel,
    input  logic [PAGE_W-1:0] rd_page,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic [7:0]        status
);

    logic              s_main_we, s_buf_we, s_sel;
    logic [7:0]        s_main_wd, s_main_rd, s_buf_rd;
    logic [PAGE_W-1:0] s_page;
    logic [IDX_W-1:0]  s_idx;

    logic              m_we, b_we, b_sel;
    logic [PAGE_W-1:0] m_page;
    logic [IDX_W-1:0]  m_idx, b_idx;
    logic [7:0]        m_wd, b_wd;

    pbs_seq #(
        .STD_LEN(STD_LEN), .BIN_LEN(BIN_LEN),
        .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES),
        .IDX_W(IDX_W), .PAGE_W(PAGE_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_buf(cmd_buf),
        .cmd_page(cmd_page), .cmd_bin(cmd_bin),
        .main_rd(s_main_rd), .buf_rd(s_buf_rd),
        .main_we(s_main_we), .main_wd(s_main_wd), .buf_we(s_buf_we),
        .cur_page(s_page), .cur_sel(s_sel), .cur_idx(s_idx),
        .busy(busy), .status(status)
    );

    // host owns the write ports only while idle
    always_comb begin
        if (busy) begin
            m_we   = s_main_we;
            m_page = s_page;
            m_idx  = s_idx;
            m_wd   = s_main_wd;
            b_we   = s_buf_we;
            b_sel  = s_sel;
            b_idx  = s_idx;
            b_wd   = s_main_rd;
        end else begin
            m_we   = host_we && (host_sel == TGT_MAIN);
            m_page = host_page;
            m_idx  = host_idx;
            m_wd   = host_wdata;
            b_we   = host_we && (host_sel == TGT_BUF0 || host_sel == TGT_BUF1);
            b_sel  = host_sel[0];
            b_idx  = host_idx;
            b_wd   = host_wdata;
        end
    end

    pbs_store #(
        .PAGES(PAGES), .LEN(STD_LEN), .IDX_W(IDX_W), .PAGE_W(PAGE_W)
    ) u_store (
        .clk(clk),
        .main_we(m_we), .main_page(m_page), .main_idx(m_idx), .main_wd(m_wd),
        .buf_we(b_we), .buf_sel(b_sel), .buf_idx(b_idx), .buf_wd(b_wd),
        .seq_page(s_page), .seq_sel(s_sel), .seq_idx(s_idx),
        .seq_main_rd(s_main_rd), .seq_buf_rd(s_buf_rd),
        .h_sel(rd_sel), .h_page(rd_page), .h_idx(rd_idx), .h_rd(rd_data)
    );

    // R8
    host_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !s_main_we) |-> !m_we);

endmodule

// File: tb/page_op_sequencer_test.sv
module page_op_sequencer_test;

    localparam int PAGES = 4, STD = 17, BIN = 16, EC = 5, PC = 4;
    localparam int IW = $clog2(STD), PW = $clog2(PAGES);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_go = 0, cmd_buf = 0, cmd_bin = 0;
    logic [1:0] cmd_op = 2'b11;
    logic [PW-1:0] cmd_page = '0;
    logic host_we = 0;
    logic [1:0] host_sel = 2'd3;
    logic [PW-1:0] host_page = '0;
    logic [IW-1:0] host_idx = '0;
    logic [7:0] host_wdata = '0;
    logic [1:0] rd_sel = 2'd3;
    logic [PW-1:0] rd_page = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [7:0] rd_data, status;
    logic busy;

    always #10 clk = ~clk;

    page_op_sequencer #(.PAGES(PAGES), .STD_LEN(STD), .BIN_LEN(BIN),
                        .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op),
        .cmd_buf(cmd_buf), .cmd_page(cmd_page), .cmd_bin(cmd_bin),
        .host_we(host_we), .host_sel(host_sel), .host_page(host_page),
        .host_idx(host_idx), .host_wdata(host_wdata),
        .rd_sel(rd_sel), .rd_page(rd_page), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .status(status));

    typedef struct {
        int sel; int page; int idx; int exp; string tag;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int mm [PAGES][STD];
    int bb [2][STD];

    function automatic void chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    function automatic void push(int sel, int page, int idx, int exp, string tag);
        item_t it;
        it.sel = sel; it.page = page; it.idx = idx; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endfunction

    // monitor: owns the read port, drains the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                rd_sel  = 2'(it.sel);
                rd_page = PW'(it.page);
                rd_idx  = IW'(it.idx);
                #2;
                chk(rd_data == 8'(it.exp), it.tag, int'(rd_data), it.exp);
            end
        end
    end

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic hwrite(int sel, int page, int idx, int val);
        @(negedge clk);
        host_we = 1; host_sel = 2'(sel); host_page = PW'(page);
        host_idx = IW'(idx); host_wdata = 8'(val);
        @(negedge clk);
        host_we = 0; host_sel = 2'd3;
        if (sel == 2) mm[page][idx] = val & 255;
        else if (sel < 2) bb[sel][idx] = val & 255;
    endtask

    task automatic push_page(int p, string tag);
        for (int i = 0; i < STD; i++) push(2, p, i, mm[p][i], tag);
    endtask

    task automatic push_buf(int b, string tag);
        for (int i = 0; i < STD; i++) push(b, 0, i, bb[b][i], tag);
    endtask

    // inj: 0 none, 1 strobe while busy, 2 host write while busy
    task automatic run_op(int op, int bsel, int page, int bin, int inj, string tag);
        int len, expn, j;
        len  = bin ? BIN : STD;
        expn = (op == 2) ? 3 * len + EC + PC : len;
        @(negedge clk);
        cmd_go = 1; cmd_op = 2'(op); cmd_buf = bsel[0];
        cmd_page = PW'(page); cmd_bin = bin[0];
        @(negedge clk);
        cmd_go = 0; cmd_op = 2'b11;
        chk(status[7] == 1'b0, "R6 ready bit low while busy", int'(status[7]), 0);
        j = 0;
        while (busy && j < 1000) begin
            if (op == 2 && j == 2 * len) begin
                push(2, page, 0, 8'hFF, "R5 erased first byte");
                push(2, page, len - 1, 8'hFF, "R5 erased last byte");
            end
            if (inj == 1 && j == 2) begin
                cmd_go = 1; cmd_op = 2'b01; cmd_page = PW'(page + 1);
                cmd_buf = ~cmd_buf;
            end
            if (inj == 1 && j == 3) begin cmd_go = 0; cmd_op = 2'b11; end
            if (inj == 2 && j == 3) begin
                host_we = 1; host_sel = 2'd2; host_page = PW'(page ^ 1);
                host_idx = '0; host_wdata = 8'h5A;
            end
            if (inj == 2 && j == 4) begin host_we = 0; host_sel = 2'd3; end
            j++;
            @(negedge clk);
        end
        chk(j == expn, {tag, " busy length"}, j, expn);
        chk(status[7] == 1'b1, "R6 ready bit back", int'(status[7]), 1);
        // model update
        if (op == 0 || op == 2)
            for (int i = 0; i < len; i++) bb[bsel][i] = mm[page][i];
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(status == 8'h80, "R1 status after reset", int'(status), 8'h80);

        for (int p = 0; p < PAGES; p++)
            for (int i = 0; i < STD; i++) hwrite(2, p, i, p * 37 + i * 5 + 1);
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < STD; i++) hwrite(b, 0, i, 8'hA0 + b * 16 + i);
        push_page(3, "R8 host load main");
        push_buf(1, "R8 host load buffer");
        push(3, 0, 0, 0, "R8 selector 3 reads zero");
        drain();

        // R2 copy page 1 into first buffer, standard length
        run_op(0, 0, 1, 0, 0, "R2 copy std");
        push_buf(0, "R2 copied bytes");
        push_buf(1, "R2 other buffer untouched");
        push_page(1, "R2 page untouched");
        drain();

        // R3 copy page 2 into second buffer, binary length
        run_op(0, 1, 2, 1, 0, "R3 copy bin");
        push_buf(1, "R3 binary copy keeps tail byte");
        drain();

        // R4 check match
        run_op(1, 0, 1, 0, 0, "R4 check match");
        chk(status == 8'h80, "R4 match flag", int'(status), 8'h80);

        // R4 last-byte mismatch
        hwrite(0, 0, STD - 1, 8'h33);
        run_op(1, 0, 1, 0, 0, "R4 check last byte");
        chk(status == 8'hC0, "R4 last byte mismatch flag", int'(status), 8'hC0);
        push_page(1, "R4 check leaves page");
        push_buf(0, "R4 check leaves buffer");
        drain();

        // R3 binary check skips tail byte
        run_op(1, 0, 1, 1, 0, "R3 check bin");
        chk(status == 8'h80, "R3 binary check ignores tail", int'(status), 8'h80);

        // R9 flag survives copy
        run_op(1, 0, 0, 0, 0, "R4 check differ");
        chk(status == 8'hC0, "R4 mismatch flag", int'(status), 8'hC0);
        run_op(0, 1, 0, 0, 0, "R9 copy");
        chk(status == 8'hC0, "R9 flag kept after copy", int'(status), 8'hC0);
        push_buf(1, "R9 copy data");
        drain();

        // R5 refresh page 3 through first buffer
        run_op(2, 0, 3, 0, 0, "R5 refresh std");
        chk(status == 8'hC0, "R9 flag kept after refresh", int'(status), 8'hC0);
        drain();
        push_page(3, "R5 page restored");
        push_buf(0, "R5 buffer holds page");
        drain();

        // R5 refresh in binary mode, second buffer
        hwrite(1, 0, 0, 8'h11);
        run_op(2, 1, 0, 1, 0, "R5 refresh bin");
        drain();
        push_page(0, "R5 bin page restored");
        push_buf(1, "R5 bin buffer");
        drain();

        // R7 reserved code ignored
        @(negedge clk);
        cmd_go = 1; cmd_op = 2'b11;
        @(negedge clk);
        cmd_go = 0;
        chk(busy == 1'b0, "R7 reserved code no busy", int'(busy), 0);

        // R7 strobe while busy
        run_op(0, 0, 2, 0, 1, "R7 strobe while busy");
        chk(status == 8'hC0, "R7 flag untouched by ignored check", int'(status), 8'hC0);
        push_buf(0, "R7 copy unaffected");
        push_buf(1, "R7 other buffer unaffected");
        drain();

        // R8 host write while busy
        run_op(0, 1, 2, 0, 2, "R8 write while busy");
        push_page(3, "R8 blocked host write");
        drain();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule